// File: doc/BRIEF.md
# Per-Channel Pedestal and Threshold Hit Sparsifier

This block sits behind a front-end digitiser that delivers every channel on every bunch crossing, with no suppression. Each incoming sample carries a channel number and a crossing number. The block takes away that channel's stored pedestal from the sample. It then compares the result with that channel's stored threshold. Samples that clear the threshold leave as labelled 32-bit hit words on a valid/ready stream. All other samples disappear.

Suppressed data arrives in bursts, so a 16-entry FIFO sits in front of the output to smooth it out. The pedestal and threshold tables are loaded through a single-cycle write port, and a select bit chooses which table is written. When the FIFO is full, new hits are thrown away and a sticky overflow flag records the loss. This lets downstream software know that the crossing data is incomplete.

Top module: `hit_sparsifier`

## Requirements
- R1: After reset, `hit_valid` and `hit_overflow` are 0, and every pedestal and threshold entry is 0. A sample with a nonzero 14-bit value is therefore kept unchanged.
- R2: Only the low 14 bits of the 16-bit `smp_data` container are used. Bits 15:14 have no effect on the hit.
- R3: The pedestal subtraction saturates at zero. A sample at or below its channel's pedestal is never kept.
- R4: A sample is kept only when (sample − pedestal) is strictly greater than the channel's threshold. Equality drops the sample.
- R5: The hit word is {crossing[12:0] in bits 31:19, channel[6:0] in bits 18:12, amplitude[11:0] in bits 11:0}.
- R6: The amplitude field saturates at 0xFFF when the pedestal-subtracted value exceeds 4095.
- R7: `cfg_sel`=0 writes the pedestal and `cfg_sel`=1 writes the threshold of channel `cfg_chan`. Writes change only that channel's entry. A sample in the same cycle as the write still sees the old value, and samples from the next cycle onward see the new one.
- R8: The FIFO holds up to 16 hits and returns them in arrival order. While `hit_valid` is high and `hit_ready` is low, `hit_data` stays stable.
- R9: A hit that arrives while the FIFO holds 16 entries is discarded and sets `hit_overflow`. The flag stays set until reset.
- R10: A kept sample accepted at clock edge k makes `hit_valid` high after edge k+1 when the FIFO was empty. It is not visible before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Sample present this cycle |
| smp_chan | input | 7 | Channel number of the sample |
| smp_xing | input | 13 | Crossing number of the sample |
| smp_data | input | 16 | Sample container, low 14 bits significant |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 1 | 0 = pedestal table, 1 = threshold table |
| cfg_chan | input | 7 | Channel whose entry is written |
| cfg_value | input | 14 | Value written |
| hit_valid | output | 1 | Hit word available |
| hit_ready | input | 1 | Consumer accepts the hit word |
| hit_data | output | 32 | Labelled hit word |
| hit_overflow | output | 1 | Sticky flag: a hit was lost to a full FIFO |

## Verification
Two events can land in the same cycle: a table write and a sample on the same channel. The bench provokes this by pulsing `cfg_we` and `smp_valid` together. It then checks that the result matches the old pedestal, and that the sample on the next cycle matches the new one. A second collision is a hit arriving while the output is stalled and the FIFO is full. The bench fills the FIFO with `hit_ready` low and sends one extra hit. It then checks that `hit_overflow` rises, that the head word does not move, and that exactly the first 16 hits drain in order.

// File: rtl/sprs_pkg.sv
package sprs_pkg;
  parameter int CHAN_W = 7;
  parameter int XING_W = 13;
  parameter int CONT_W = 16;
  parameter int ADC_W  = 14;
  parameter int AMP_W  = 12;
  parameter int FIFO_DEPTH = 16;

  localparam int HIT_W    = XING_W + CHAN_W + AMP_W;
  localparam int NUM_CHAN = 1 << CHAN_W;
  localparam int NUM_TBL  = 2;  // index 0 pedestal, index 1 threshold

  typedef struct packed {
    logic [XING_W-1:0] xing;
    logic [CHAN_W-1:0] chan;
    logic [AMP_W-1:0]  amp;
  } hit_t;
endpackage

// File: rtl/sprs_cal_table.sv
module sprs_cal_table #(
  parameter int ADDR_W = 7,
  parameter int VAL_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [VAL_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [VAL_W-1:0]  rd_data
);
  localparam int ENTRIES = 1 << ADDR_W;

  logic [VAL_W-1:0] entry_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic entry_en;
    assign entry_en = wr_en && (wr_addr == ADDR_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        entry_q[e] <= '0;
      else if (entry_en) entry_q[e] <= wr_data;
    end
  end

  assign rd_data = entry_q[rd_addr];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (entry_q[$past(wr_addr)] == $past(wr_data))); // R7
endmodule

// File: rtl/sprs_discriminator.sv
module sprs_discriminator
  import sprs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [CHAN_W-1:0] smp_chan,
  input  logic [XING_W-1:0] smp_xing,
  input  logic [CONT_W-1:0] smp_data,
  input  logic [ADC_W-1:0]  ped,
  input  logic [ADC_W-1:0]  thr,
  output logic              cand_valid,
  output logic [HIT_W-1:0]  cand_word
);
  logic [ADC_W-1:0] adc;
  logic [ADC_W-1:0] diff;
  logic [AMP_W-1:0] amp;
  logic             keep;
  logic             unused_hi;
  hit_t             word_nxt;
  logic             valid_q;
  logic [HIT_W-1:0] word_q;

  assign adc       = smp_data[ADC_W-1:0];
  assign unused_hi = ^smp_data[CONT_W-1:ADC_W];

  always_comb begin
    diff = (adc > ped) ? (adc - ped) : '0;
    amp  = (|diff[ADC_W-1:AMP_W]) ? '1 : diff[AMP_W-1:0];
    keep = smp_valid && (diff > thr);
    word_nxt.xing = smp_xing;
    word_nxt.chan = smp_chan;
    word_nxt.amp  = amp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (keep) word_q <= word_nxt;
  end

  assign cand_valid = valid_q;
  assign cand_word  = word_q;

  AST_NO_ZERO_AMP: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> (cand_word[AMP_W-1:0] != '0)); // R4
  AST_BELOW_PED_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (adc <= ped)) |=> !cand_valid); // R3
  AST_LABEL_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> (cand_word[HIT_W-1:AMP_W] == {$past(smp_xing), $past(smp_chan)})); // R5
endmodule

// File: rtl/sprs_hit_fifo.sv
module sprs_hit_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_ready,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  output logic             overflow
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_nxt, rd_ptr_q, rd_ptr_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             ovf_q, ovf_nxt;
  logic             full, wr_ok, rd_ok;

  assign full  = (cnt_q == FULL_CNT);
  assign wr_ok = push && !full;
  assign rd_ok = out_valid && pop_ready;

  always_comb begin
    wr_ptr_nxt = wr_ptr_q;
    rd_ptr_nxt = rd_ptr_q;
    cnt_nxt    = cnt_q;
    ovf_nxt    = ovf_q | (push && full);
    if (wr_ok) wr_ptr_nxt = (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + PTR_W'(1);
    if (rd_ok) rd_ptr_nxt = (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + PTR_W'(1);
    case ({wr_ok, rd_ok})
      2'b10:   cnt_nxt = cnt_q + CNT_W'(1);
      2'b01:   cnt_nxt = cnt_q - CNT_W'(1);
      default: cnt_nxt = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_nxt;
      rd_ptr_q <= rd_ptr_nxt;
      cnt_q    <= cnt_nxt;
      ovf_q    <= ovf_nxt;
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_ok && (wr_ptr_q == PTR_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q[s] <= '0;
      else if (slot_en) slot_q[s] <= push_data;
    end
  end

  assign out_valid = (cnt_q != '0);
  assign out_data  = slot_q[rd_ptr_q];
  assign overflow  = ovf_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT); // R8
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !pop_ready) |=> (out_valid && $stable(out_data))); // R8
  AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R9
  AST_FULL_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> (overflow && (cnt_q == FULL_CNT || $past(pop_ready)))); // R9
endmodule

// File: rtl/hit_sparsifier.sv
module hit_sparsifier
  import sprs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_valid,
  input  logic [6:0]  smp_chan,
  input  logic [12:0] smp_xing,
  input  logic [15:0] smp_data,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [6:0]  cfg_chan,
  input  logic [13:0] cfg_value,
  output logic        hit_valid,
  input  logic        hit_ready,
  output logic [31:0] hit_data,
  output logic        hit_overflow
);
  logic             rst_meta_q, rst_sync_q;
  logic [ADC_W-1:0] tbl_rd [NUM_TBL];
  logic             cand_valid;
  logic [HIT_W-1:0] cand_word;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
    logic tbl_we;
    assign tbl_we = cfg_we && (cfg_sel == 1'(t));
    sprs_cal_table #(.ADDR_W(CHAN_W), .VAL_W(ADC_W)) i_tbl (
      .clk     (clk),
      .rst_n   (rst_sync_q),
      .wr_en   (tbl_we),
      .wr_addr (cfg_chan),
      .wr_data (cfg_value),
      .rd_addr (smp_chan),
      .rd_data (tbl_rd[t])
    );
  end

  sprs_discriminator i_disc (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .smp_valid  (smp_valid),
    .smp_chan   (smp_chan),
    .smp_xing   (smp_xing),
    .smp_data   (smp_data),
    .ped        (tbl_rd[0]),
    .thr        (tbl_rd[1]),
    .cand_valid (cand_valid),
    .cand_word  (cand_word)
  );

  sprs_hit_fifo #(.WIDTH(HIT_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .push      (cand_valid),
    .push_data (cand_word),
    .pop_ready (hit_ready),
    .out_valid (hit_valid),
    .out_data  (hit_data),
    .overflow  (hit_overflow)
  );

  AST_ONE_HIT_PER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    cand_valid |-> $past(smp_valid)); // R10
endmodule

// File: tb/test_hit_sparsifier.sv
module test_hit_sparsifier;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_valid;
  logic [6:0]  smp_chan;
  logic [12:0] smp_xing;
  logic [15:0] smp_data;
  logic        cfg_we;
  logic        cfg_sel;
  logic [6:0]  cfg_chan;
  logic [13:0] cfg_value;
  logic        hit_valid;
  logic        hit_ready;
  logic [31:0] hit_data;
  logic        hit_overflow;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hit_sparsifier i_hit_sparsifier (.*);

  // {chan, xing, data, keep, expected word}
  localparam int NV = 10;
  localparam logic [68:0] VEC [NV] = '{
    {7'd5,   13'd1,    16'd200,    1'b1, 13'd1,    7'd5,   12'd100},  // R5 basic
    {7'd5,   13'd2,    16'd120,    1'b0, 32'd0},                     // R4 equal
    {7'd5,   13'd3,    16'd121,    1'b1, 13'd3,    7'd5,   12'd21},   // R4 one above
    {7'd5,   13'd4,    16'd50,     1'b0, 32'd0},                     // R3 below ped
    {7'd6,   13'd5,    16'hC007,   1'b1, 13'd5,    7'd6,   12'd7},    // R2 high bits
    {7'd6,   13'd6,    16'h3FFF,   1'b1, 13'd6,    7'd6,   12'hFFF},  // R6 saturate
    {7'd127, 13'd8191, 16'h3FFF,   1'b1, 13'd8191, 7'd127, 12'hFFF},  // R5 all ones
    {7'd127, 13'd9,    16'd4050,   1'b0, 32'd0},                     // R4 big thr
    {7'd0,   13'd10,   16'd9001,   1'b1, 13'd10,   7'd0,   12'd1},    // R3 big ped
    {7'd0,   13'd11,   16'd9000,   1'b0, 32'd0}                      // R3 at ped
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic sel, input logic [6:0] ch, input logic [13:0] v);
    cfg_we = 1'b1; cfg_sel = sel; cfg_chan = ch; cfg_value = v;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [6:0] ch, input logic [12:0] x, input logic [15:0] d);
    smp_valid = 1'b1; smp_chan = ch; smp_xing = x; smp_data = d;
    step();
    smp_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    smp_valid = 0; smp_chan = 0; smp_xing = 0; smp_data = 0;
    cfg_we = 0; cfg_sel = 0; cfg_chan = 0; cfg_value = 0;
    hit_ready = 1'b1;
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 valid", 32'(hit_valid), 32'd0);
    chk("R1 overflow", 32'(hit_overflow), 32'd0);
    // R1 zero tables, R10 latency
    send(7'd20, 13'd42, 16'd5);
    chk("R10 not before k+1", 32'(hit_valid), 32'd0);
    step();
    chk("R10 valid at k+1", 32'(hit_valid), 32'd1);
    chk("R1 zero tables word", hit_data, {13'd42, 7'd20, 12'd5});
    step();

    // table setup
    write_cfg(1'b0, 7'd5, 14'd100);
    write_cfg(1'b1, 7'd5, 14'd20);
    write_cfg(1'b0, 7'd127, 14'd50);
    write_cfg(1'b1, 7'd127, 14'd4000);
    write_cfg(1'b0, 7'd0, 14'd9000);

    for (int v = 0; v < NV; v++) begin
      send(VEC[v][68:62], VEC[v][61:49], VEC[v][48:33]);
      step();
      chk($sformatf("R4/R5 vec%0d valid", v), 32'(hit_valid), 32'(VEC[v][32]));
      if (VEC[v][32]) chk($sformatf("R5 vec%0d word", v), hit_data, VEC[v][31:0]);
    end
    step();

    // R7 write and sample in the same cycle
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_chan = 7'd30; cfg_value = 14'd10;
    smp_valid = 1'b1; smp_chan = 7'd30; smp_xing = 13'd100; smp_data = 16'd8;
    step();
    cfg_we = 1'b0; smp_xing = 13'd101;
    step();
    smp_valid = 1'b0;
    chk("R7 same-cycle old ped", 32'(hit_valid), 32'd1);
    chk("R7 same-cycle word", hit_data, {13'd100, 7'd30, 12'd8});
    step();
    chk("R7 next sample new ped", 32'(hit_valid), 32'd0);

    // R7 per-channel isolation
    write_cfg(1'b1, 7'd31, 14'd100);
    send(7'd32, 13'd200, 16'd50);
    step();
    chk("R7 neighbour untouched", hit_data, {13'd200, 7'd32, 12'd50});
    step();

    // R8 / R9 stall, fill and overflow
    hit_ready = 1'b0;
    for (int i = 0; i < 16; i++) begin
      smp_valid = 1'b1; smp_chan = 7'd40; smp_xing = 13'(i); smp_data = 16'(i + 1);
      step();
    end
    smp_valid = 1'b0;
    step();
    chk("R9 no overflow at 16", 32'(hit_overflow), 32'd0);
    send(7'd40, 13'd16, 16'd17);
    step();
    chk("R9 overflow set", 32'(hit_overflow), 32'd1);
    chk("R8 head held", hit_data, {13'd0, 7'd40, 12'd1});
    hit_ready = 1'b1;
    for (int i = 0; i < 16; i++) begin
      chk("R8 drain valid", 32'(hit_valid), 32'd1);
      chk("R8 drain order", hit_data, {13'(i), 7'd40, 12'(i + 1)});
      step();
    end
    chk("R9 extra hit dropped", 32'(hit_valid), 32'd0);
    chk("R9 sticky", 32'(hit_overflow), 32'd1);

    // R1 reset clears flag and tables
    do_reset();
    chk("R1 overflow cleared", 32'(hit_overflow), 32'd0);
    send(7'd5, 13'd7, 16'd3);
    step();
    chk("R1 ped cleared", hit_data, {13'd7, 7'd5, 12'd3});
    step();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule